// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver Section

This block is one section of a bus transceiver that moves a word between two ports, A and B, in either direction. Each direction has a storage register and a select line. The word sent toward the far side is either the live input of the near side (transparent) or the last word captured from it (registered). An active-low output enable and a direction input decide which port drives, if either does. The ports are split into separate input, output and per-bit output-enable vectors, so no tri-state nets are needed. Two instances with their controls tied together form a double-width transceiver.

Capture is edge-triggered on two strobe inputs, one per direction. The block samples the strobes on the system clock `clk`. A strobe sampled high after a cycle in which it was low loads the matching register from its port's input pins at that same clock edge. Capture ignores the enable and the direction, so a register can be loaded while its side is isolated or while it is driving. A synchronous active-high reset clears both registers and both edge trackers.

Top module: `xcvr_section`

## Requirements
- R1: With `oe_n` low and `dir` high, every bit of `b_oe` is 1 and every bit of `a_oe` is 0.
- R2: With `oe_n` low and `dir` low, every bit of `a_oe` is 1 and every bit of `b_oe` is 0.
- R3: With `oe_n` high, `a_oe`, `b_oe`, `a_o` and `b_o` are all zero, whatever the other inputs are.
- R4: While B is driven and `sel_ab` is 0, `b_o` equals `a_i` in the same cycle.
- R5: While B is driven and `sel_ab` is 1, `b_o` equals the stored A word and does not follow changes on `a_i`.
- R6: While A is driven, `a_o` equals `b_i` when `sel_ba` is 0 and equals the stored B word when `sel_ba` is 1.
- R7: The stored A word takes the value of `a_i` at a clock edge where `cap_ab` is 1 and was 0 at the previous edge. At every other edge it keeps its value, including while `cap_ab` is held at 1.
- R8: The stored B word follows the same rule with `cap_ba` and `b_i`.
- R9: Capture into either register happens regardless of `oe_n` and `dir`.
- R10: A clock edge with `rst` high clears both stored words to zero and the remembered strobe levels to 0.
- R11: The data output of a port that is not driving is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: drive B from the A path, 0: drive A from the B path |
| cap_ab | input | 1 | Capture strobe for the A register (rising edge) |
| cap_ba | input | 1 | Capture strobe for the B register (rising edge) |
| sel_ab | input | 1 | 0: live A to B, 1: stored A to B |
| sel_ba | input | 1 | 0: live B to A, 1: stored B to A |
| a_i | input | W | A port input pins |
| b_i | input | W | B port input pins |
| a_o | output | W | A port output data |
| a_oe | output | W | A port per-bit drive enable |
| b_o | output | W | B port output data |
| b_oe | output | W | B port per-bit drive enable |

## Verification
The assertions check the decode of enable and direction into the per-bit enables on every cycle, together with zeroed outputs on the idle side. They also check transparent pass-through against the live input, registered output against the internal stored word, the load-on-rising-strobe rule, hold at every other edge, and the clearing by reset. Some things only the bench scenarios can show. A strobe held high across many cycles must not reload. A word captured while its side is isolated or driving must appear later when the select is switched. Registered output must stay fixed while the live input moves. A randomized mix of all controls is compared against an independent model on every clock.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'b00,
        DRV_TO_B = 2'b01,
        DRV_TO_A = 2'b10
    } drv_e;

    typedef struct packed {
        logic strobe;
        logic sel;
        logic drive;
    } lane_ctl_t;

    localparam int LANES = 2;
    localparam int LANE_AB = 0;
    localparam int LANE_BA = 1;

    function automatic drv_e drv_decode(input logic oe_n, input logic dir);
        if (oe_n) return DRV_OFF;
        return dir ? DRV_TO_B : DRV_TO_A;
    endfunction

endpackage

// File: rtl/xcvr_drive_dec.sv
module xcvr_drive_dec
    import xcvr_pkg::*;
(
    input  logic oe_n,
    input  logic dir,
    output drv_e drv,
    output logic drive_a,
    output logic drive_b
);
    always_comb begin
        drv     = drv_decode(oe_n, dir);
        drive_a = (drv == DRV_TO_A);
        drive_b = (drv == DRV_TO_B);
    end
endmodule

// File: rtl/xcvr_edge_store.sv
module xcvr_edge_store #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic strobe_q;
    logic load;

    assign load = strobe & ~strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            q        <= '0;
        end else begin
            strobe_q <= strobe;
            if (load) q <= din;
        end
    end
endmodule

// File: rtl/xcvr_lane_mux.sv
module xcvr_lane_mux #(
    parameter int W = 9
) (
    input  logic         drive,
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe
);
    always_comb begin
        oe   = {W{drive}};
        dout = '0;
        if (drive) dout = sel ? stored : live;
    end
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_o,
    output logic [W-1:0] b_oe
);
    drv_e drv;
    logic drive_a, drive_b;

    lane_ctl_t         ctl    [LANES];
    logic [W-1:0]      src    [LANES];
    logic [W-1:0]      held   [LANES];
    logic [W-1:0]      dout   [LANES];
    logic [W-1:0]      doe    [LANES];

    logic [W-1:0] held_a, held_b;

    xcvr_drive_dec u_dec (
        .oe_n    (oe_n),
        .dir     (dir),
        .drv     (drv),
        .drive_a (drive_a),
        .drive_b (drive_b)
    );

    always_comb begin
        ctl[LANE_AB] = '{strobe: cap_ab, sel: sel_ab, drive: drive_b};
        ctl[LANE_BA] = '{strobe: cap_ba, sel: sel_ba, drive: drive_a};
        src[LANE_AB] = a_i;
        src[LANE_BA] = b_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xcvr_edge_store #(.W(W)) u_store (
            .clk    (clk),
            .rst    (rst),
            .strobe (ctl[g].strobe),
            .din    (src[g]),
            .q      (held[g])
        );
        xcvr_lane_mux #(.W(W)) u_mux (
            .drive  (ctl[g].drive),
            .sel    (ctl[g].sel),
            .live   (src[g]),
            .stored (held[g]),
            .dout   (dout[g]),
            .oe     (doe[g])
        );
    end

    assign held_a = held[LANE_AB];
    assign held_b = held[LANE_BA];
    assign b_o    = dout[LANE_AB];
    assign b_oe   = doe[LANE_AB];
    assign a_o    = dout[LANE_BA];
    assign a_oe   = doe[LANE_BA];
endmodule

// File: rtl/xcvr_section_chk.sv
module xcvr_section_chk #(
    parameter int W = 9
) (
    input logic         clk,
    input logic         rst,
    input logic         oe_n,
    input logic         dir,
    input logic         cap_ab,
    input logic         cap_ba,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] a_o,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_o,
    input logic [W-1:0] b_oe,
    input logic [W-1:0] held_a,
    input logic [W-1:0] held_b
);
    a_r1_drive_b: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && dir) |-> (b_oe == {W{1'b1}} && a_oe == '0));

    a_r2_drive_a: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !dir) |-> (a_oe == {W{1'b1}} && b_oe == '0));

    a_r3_isolated: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (a_oe == '0 && b_oe == '0 && a_o == '0 && b_o == '0));

    a_r4_live_ab: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && dir && !sel_ab) |-> (b_o == a_i));

    a_r5_stored_ab: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && dir && sel_ab) |-> (b_o == held_a));

    a_r6_path_ba: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !dir) |-> (a_o == (sel_ba ? held_b : b_i)));

    a_r7_load_a: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cap_ab && !$past(cap_ab)) |=> (held_a == $past(a_i)));

    a_r7_hold_a: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !(cap_ab && !$past(cap_ab))) |=> $stable(held_a));

    a_r8_load_b: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cap_ba && !$past(cap_ba)) |=> (held_b == $past(b_i)));

    a_r8_hold_b: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !(cap_ba && !$past(cap_ba))) |=> $stable(held_b));

    a_r10_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (held_a == '0 && held_b == '0));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        ((a_oe == '0) |-> (a_o == '0)) and ((b_oe == '0) |-> (b_o == '0)));
endmodule

bind xcvr_section xcvr_section_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .oe_n   (oe_n),
    .dir    (dir),
    .cap_ab (cap_ab),
    .cap_ba (cap_ba),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_i    (a_i),
    .b_i    (b_i),
    .a_o    (a_o),
    .a_oe   (a_oe),
    .b_o    (b_o),
    .b_oe   (b_oe),
    .held_a (held_a),
    .held_b (held_b)
);

// File: tb/sim_xcvr_section.sv
`timescale 1ns/1ps
module sim_xcvr_section;
    localparam int W = 9;
    localparam int WATCHDOG = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic         oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
    logic [W-1:0] a_i, b_i;
    logic [W-1:0] a_o, a_oe, b_o, b_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [W-1:0] ref_a, ref_b;
    logic         last_ab, last_ba;

    always #2 clk = ~clk;

    xcvr_section #(.W(W)) u0 (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_i(a_i), .b_i(b_i), .a_o(a_o), .a_oe(a_oe), .b_o(b_o), .b_oe(b_oe)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string mode_tag(input bit to_a);
        if (oe_n) return "R3/R11";
        if (dir && !to_a) return sel_ab ? "R5" : "R4";
        if (!dir && to_a) return "R6";
        return "R11";
    endfunction

    task automatic compare_all();
        logic [W-1:0] e_ao, e_aoe, e_bo, e_boe;
        e_aoe = (!oe_n && !dir) ? '1 : '0;
        e_boe = (!oe_n && dir)  ? '1 : '0;
        e_ao  = (!oe_n && !dir) ? (sel_ba ? ref_b : b_i) : '0;
        e_bo  = (!oe_n && dir)  ? (sel_ab ? ref_a : a_i) : '0;
        check(oe_n ? "R3" : (dir ? "R1" : "R2"), a_oe, e_aoe);
        check(oe_n ? "R3" : (dir ? "R1" : "R2"), b_oe, e_boe);
        check(mode_tag(1'b1), a_o, e_ao);
        check(mode_tag(1'b0), b_o, e_bo);
    endtask

    // Compare mid-cycle, then advance the model across one rising edge.
    task automatic step();
        #1;
        if (!rst) compare_all();
        @(posedge clk);
        if (rst) begin
            ref_a = '0; ref_b = '0; last_ab = 1'b0; last_ba = 1'b0;
        end else begin
            if (cap_ab && !last_ab) ref_a = a_i;
            if (cap_ba && !last_ba) ref_b = b_i;
            last_ab = cap_ab;
            last_ba = cap_ba;
        end
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic n_oe, input logic d, input logic sab, input logic sba);
        oe_n = n_oe; dir = d; sel_ab = sab; sel_ba = sba;
    endtask

    initial begin
        rst = 1'b1; oe_n = 1'b1; dir = 1'b1; cap_ab = 1'b0; cap_ba = 1'b0;
        sel_ab = 1'b0; sel_ba = 1'b0; a_i = '0; b_i = '0;
        ref_a = '0; ref_b = '0; last_ab = 1'b0; last_ba = 1'b0;
        @(negedge clk);
        a_i = 9'h1a5; b_i = 9'h0c3;
        step(); step();
        rst = 1'b0;

        // R10: registered outputs read zero after reset
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1); step();
        check("R10", b_o, '0);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1); step();
        check("R10", a_o, '0);

        // R1 R4: transparent A to B with several words
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        foreach (a_i[k]) begin a_i = 9'h001 << k; step(); end
        a_i = 9'h1ff; step();

        // R9 R7: capture A while isolated, then show it registered (R5)
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        a_i = 9'h15a; cap_ab = 1'b1; step();
        a_i = 9'h0f0; step();               // held high: no reload (R7)
        a_i = 9'h033; step();
        cap_ab = 1'b0;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0); step();
        check("R7", b_o, 9'h15a);
        a_i = 9'h1e1; step();
        check("R5", b_o, 9'h15a);

        // R9 R8: capture B while B is the driven side, then show on A (R2 R6)
        set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
        b_i = 9'h0aa; cap_ba = 1'b1; step();
        cap_ba = 1'b0; b_i = 9'h111; step();
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1); step();
        check("R8", a_o, 9'h0aa);
        check("R11", b_o, '0);
        sel_ba = 1'b0; b_i = 9'h1c7; step();
        check("R6", a_o, 9'h1c7);

        // R3: isolation with all other controls toggling
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1); step();
        dir = 1'b0; step();
        check("R3", a_o | b_o | a_oe | b_oe, '0);

        // Mixed randomized traffic against the model
        for (int i = 0; i < 400; i++) begin
            oe_n = $urandom_range(0, 3) == 0;
            dir = $urandom_range(0, 1) != 0;
            sel_ab = $urandom_range(0, 1) != 0;
            sel_ba = $urandom_range(0, 1) != 0;
            cap_ab = $urandom_range(0, 2) == 0;
            cap_ba = $urandom_range(0, 2) == 0;
            a_i = W'($urandom);
            b_i = W'($urandom);
            step();
        end

        // R10: reset mid-run clears both stored words
        cap_ab = 1'b0; cap_ba = 1'b0;
        rst = 1'b1; step(); rst = 1'b0;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1); step();
        check("R10", b_o, '0);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1); step();
        check("R10", a_o, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule